// File: doc/BRIEF.md
# Dual-Enable Asynchronous Static Memory

This block is a synthesizable behavioural model of a byte-wide static memory. It is selected only by a pair of enables of opposite polarity. It also has a write strobe and a read strobe, both active low. The physical three-state data pins are represented by three signals: an incoming data byte, an outgoing data byte, and a drive flag that tells the surrounding pad logic when the memory would own the bus.

Reads are combinational: the outgoing byte follows the address with no clock in the path. A write happens whenever both enables select the part and the write strobe is low. The state of the read strobe does not matter during a write. The model samples the write overlap on each rising clock edge, so the stored word follows the input data while the overlap lasts and keeps the value present at its final sampled edge. The full device uses 13 address bits (8192 words). The parameter default is kept smaller so that elaboration stays light. Contents are undefined until a location has been written.

Top module: `dual_en_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits, and every address keeps its own word independently of every other address.
- R2: When `sel_n` is 1 or `sel_h` is 0, the part is deselected: `dout_en` is 0 and no word is written.
- R3: When selected with `wr_n`=1 and `rd_n`=1, `dout_en` is 0.
- R4: When selected with `wr_n`=1 and `rd_n`=0, `dout_en` is 1. In every mode, `dout` shows the word at `addr` combinationally, in the same cycle as an address change.
- R5: When selected with `wr_n`=0, `din` is written to `addr` whatever the value of `rd_n`, and `dout_en` is 0.
- R6: A word changes only on a rising `clk` edge at which `sel_n`=0, `sel_h`=1 and `wr_n`=0 all hold at once. Any other combination leaves the array untouched.
- R7: During a write overlap that spans several edges, the word is rewritten at each edge. After the overlap ends, the word holds the `din` value sampled at its last edge.
- R8: While `rst` is 1, no word is written, even if all write conditions hold. `dout_en` still follows the mode decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the write overlap |
| rst | input | 1 | Synchronous active-high reset; blocks writes while high |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low select |
| sel_h | input | 1 | Active-high select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read (output) strobe |
| din | input | DATA_W | Data to store |
| dout | output | DATA_W | Word at the current address |
| dout_en | output | 1 | High only in read mode; stands for the bus being driven |

## Verification
The bench drives the write strobe low while only one of the two enables is active. A design that decodes just one enable would then corrupt a word, or drive the bus while deselected. It also holds the write strobe and the read strobe low together, to catch a design that lets the read strobe win and drives the bus during a write. It holds a write across several edges while changing the data, then reads the word back: a design that keeps only the first sample returns a stale byte. Writes asserted during reset, and at the lowest and highest addresses, expose a design that ignores the reset gate or decodes the address short.

// File: rtl/dsram_pkg.sv
package dsram_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_HIZ   = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } mode_e;

    typedef struct packed {
        logic sel_n;
        logic sel_h;
        logic wr_n;
        logic rd_n;
    } ctl_s;

    // Write strobe dominates the read strobe once the part is selected.
    function automatic mode_e decode_mode(input ctl_s c);
        if (c.sel_n || !c.sel_h) return MODE_IDLE;
        if (!c.wr_n)             return MODE_WRITE;
        if (!c.rd_n)             return MODE_READ;
        return MODE_HIZ;
    endfunction

endpackage

// File: rtl/dsram_mode_decode.sv
module dsram_mode_decode
    import dsram_pkg::*;
(
    input  logic  rst,
    input  ctl_s  ctl,
    output mode_e mode,
    output logic  wr_strobe
);
    always_comb begin
        mode      = decode_mode(ctl);
        wr_strobe = (mode == MODE_WRITE) && !rst;
    end
endmodule

// File: rtl/dsram_storage.sv
module dsram_storage #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wr_data;
        end
    end

    assign rd_data = cells[addr];
endmodule

// File: rtl/dsram_drive.sv
module dsram_drive
    import dsram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  mode_e             mode,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    always_comb begin
        dout    = word;
        dout_en = (mode == MODE_READ);
    end
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
    import dsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              sel_h,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    ctl_s              ctl;
    mode_e             mode;
    logic              wr_strobe;
    logic [DATA_W-1:0] word;

    assign ctl = '{sel_n: sel_n, sel_h: sel_h, wr_n: wr_n, rd_n: rd_n};

    dsram_mode_decode u_dec (
        .rst       (rst),
        .ctl       (ctl),
        .mode      (mode),
        .wr_strobe (wr_strobe)
    );

    dsram_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_strobe),
        .addr    (addr),
        .wr_data (din),
        .rd_data (word)
    );

    dsram_drive #(.DATA_W(DATA_W)) u_drv (
        .mode    (mode),
        .word    (word),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/dsram_chk.sv
module dsram_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              sel_n,
    input logic              sel_h,
    input logic              wr_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);
    logic selected;
    logic writing;
    assign selected = !sel_n && sel_h;
    assign writing  = selected && !wr_n;

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !selected |-> !dout_en);

    // R3
    out_off_chk: assert property (@(posedge clk) disable iff (rst)
        (selected && wr_n && rd_n) |-> !dout_en);

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (selected && wr_n && !rd_n) |-> dout_en);

    // R5
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        writing |-> !dout_en);

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        writing |=> (addr != $past(addr) || dout == $past(din)));

    // R6
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !writing |=> (addr != $past(addr) || dout == $past(dout)));
endmodule

bind dual_en_sram dsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .sel_n   (sel_n),
    .sel_h   (sel_h),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/tb_dual_en_sram.sv
`timescale 1ns/1ps
module tb_dual_en_sram;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          sel_n, sel_h, wr_n, rd_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    logic [DW-1:0] shadow [DEPTH];
    logic          known  [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_en_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .sel_n(sel_n), .sel_h(sel_h),
        .wr_n(wr_n), .rd_n(rd_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic exp_drive(logic sn, logic sh, logic wn, logic rn);
        return !sn && sh && wn && !rn;
    endfunction

    function automatic logic exp_write(logic r, logic sn, logic sh, logic wn);
        return !r && !sn && sh && !wn;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs, then update the shadow at posedge.
    task automatic step(input logic r, input logic [AW-1:0] a, input logic sn, input logic sh,
                        input logic wn, input logic rn, input logic [DW-1:0] d, input string req);
        @(negedge clk);
        rst = r; addr = a; sel_n = sn; sel_h = sh; wr_n = wn; rd_n = rn; din = d;
        #1;
        check(dout_en == exp_drive(sn, sh, wn, rn), req, dout_en, exp_drive(sn, sh, wn, rn));
        if (known[a]) check(dout == shadow[a], {req, " R4 data"}, dout, shadow[a]);
        @(posedge clk);
        if (exp_write(r, sn, sh, wn)) begin
            shadow[a] = d;
            known[a]  = 1'b1;
        end
    endtask

    task automatic expect_word(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
        @(negedge clk);
        rst = 1'b0; addr = a; sel_n = 1'b0; sel_h = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
        #1;
        check(dout_en == 1'b1, {req, " drive"}, dout_en, 1);
        check(dout == v, req, dout, v);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        rst = 1'b1; addr = '0; sel_n = 1'b1; sel_h = 1'b0; wr_n = 1'b1; rd_n = 1'b1; din = '0;
        @(posedge clk);
        // reset state, R2
        step(1'b1, 11'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R2 reset");

        // R1 boundaries: lowest and highest word
        step(1'b0, 11'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, "R5 write lo");
        step(1'b0, 11'(DEPTH-1), 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, "R5 write hi rd_n low");
        expect_word(11'd0, 8'hA5, "R1 low word");
        expect_word(11'(DEPTH-1), 8'h5A, "R1 high word");

        // R3 output-off mode
        step(1'b0, 11'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R3 out off");

        // R6: strobe low with only one select active
        step(1'b0, 11'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hEE, "R6 sel_h low");
        step(1'b0, 11'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hDD, "R6 sel_n high");
        expect_word(11'd0, 8'hA5, "R6 word kept");

        // R7: long overlap with changing data
        step(1'b0, 11'd9, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11, "R7 edge1");
        step(1'b0, 11'd9, 1'b0, 1'b1, 1'b0, 1'b0, 8'h22, "R7 edge2");
        step(1'b0, 11'd9, 1'b0, 1'b1, 1'b0, 1'b1, 8'h33, "R7 edge3");
        expect_word(11'd9, 8'h33, "R7 last value");

        // R8: writes blocked in reset
        step(1'b1, 11'd9, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, "R8 reset write");
        expect_word(11'd9, 8'h33, "R8 word kept");

        // Random traffic over a small window plus the top word
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [3:0]    c;
            a = ($urandom % 8 == 0) ? 11'(DEPTH-1) : 11'($urandom % 16);
            c = 4'($urandom);
            step(($urandom % 50) == 0, a, c[0] & c[1], c[2] | c[3] | c[0],
                 ($urandom % 3) != 0, c[1], 8'($urandom), "R1 R4 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule